// File: doc/BRIEF.md
# Serial Burst Memory Download Port

This block is a slave serial port that works in one of two ways. In its normal role it is a register-access port: it hands the serial line to a register decoder, which sits outside this block and appears here only as a select output and a data-out input. It can also be armed ahead of time for a burst memory download, which is used to load instruction or coefficient firmware. Arming needs three configuration inputs to be set while chip select is high. When chip select then falls, the port enters burst mode instead of register mode.

In burst mode there is no command or address phase. The host keeps chip select low and clocks data in least significant bit first. Every 32 bits form one word, and each word is written to memory. The first word goes to a 21-bit start address that was loaded beforehand. The address then steps up by one after each word, so consecutive words need only data. Raising chip select ends the burst, drops any partial word and returns the port to register access. While the burst lasts, the port asks the rest of the device to mute its output and to hold decoding aborted. The host gets no acknowledgement of any kind.

The serial clock, chip select and data-in pins are synchronized into the system clock domain and sampled there. The serial clock must therefore run at no more than a quarter of the system clock. Each high phase and each low phase must last at least two system clocks.

Top module: `burst_dl_port`

## Requirements
- R1: When chip select falls, the port enters burst mode only if cfg_dl_i is 1, prog_mode_i is 2'b11 and mem_en_i is 1. Otherwise it enters register mode, in which reg_sel_o is 1, sdo_oe_o is 1, sdo_o follows reg_sdo_i and no memory write occurs.
- R2: In burst mode, the first data-in bit sampled on a rising serial-clock edge becomes bit 0 of the word, and the 32nd becomes bit 31.
- R3: After the rising serial-clock edge that samples bit 31, mem_we_o is high for exactly one system clock, with the assembled word on mem_wdata_o.
- R4: The first word of a burst is written to the address last loaded through addr_load_i/start_addr_i. Each later word is written to the previous address plus one.
- R5: The address counter wraps from 21'h1FFFFF to 21'h000000.
- R6: When chip select rises, the burst ends and any partial word is discarded without a write. The next burst starts on a word boundary.
- R7: mute_o and dec_abort_o are 1 while burst mode is active and 0 at all other times, including after reset.
- R8: While chip select is high, sdo_oe_o is 0, sdo_o is high-impedance, and activity on the serial clock and data-in causes no memory write.
- R9: addr_load_i has no effect while burst mode is active. The address sequence continues unbroken.
- R10: During burst mode, sdo_oe_o stays 0 and nothing is returned to the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_dl_i | input | 1 | Download configuration flag, one of the three arming conditions |
| prog_mode_i | input | 2 | Program mode; 2'b11 arms the burst |
| mem_en_i | input | 1 | Memory-access enable flag, one of the three arming conditions |
| addr_load_i | input | 1 | Loads start_addr_i into the address counter (ignored in burst) |
| start_addr_i | input | 21 | Burst start address |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, high-impedance unless in register mode |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| reg_sdo_i | input | 1 | Data-out bit from the register-access decoder |
| reg_sel_o | output | 1 | Register-access mode active; tells the decoder it owns the port |
| mem_we_o | output | 1 | Memory write strobe, one system clock wide |
| mem_addr_o | output | 21 | Memory write address |
| mem_wdata_o | output | 32 | Memory write data |
| mute_o | output | 1 | Mute request during burst |
| dec_abort_o | output | 1 | Decode-abort request during burst |

## Verification
Some properties are checked on every cycle. The write strobe is never longer than one clock, and the address steps by exactly one across each write. Burst mode is entered only when the three arming conditions were present. The output enable stays off during a burst and while chip select has been high. Other behaviour can only be shown by the bench's scenarios, which compare data and addresses end to end. These are the LSB-first bit order, the use of the loaded start address, address wrap, dropping a partial word when chip select rises, ignoring a reload during a burst, and the absence of any write in register mode or while the port is deselected.

// File: rtl/bdl_pkg.sv
package bdl_pkg;
  localparam int ADDR_W  = 21;
  localparam int WORD_W  = 32;
  localparam int PMODE_W = 2;
  localparam logic [PMODE_W-1:0] PMODE_BURST = 2'b11;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_REG   = 2'd1,
    MODE_BURST = 2'd2
  } port_mode_e;
endpackage

// File: rtl/bdl_sync.sv
module bdl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bdl_mode_ctl.sv
module bdl_mode_ctl
  import bdl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_n_s_i,
  input  logic       arm_i,
  output port_mode_e mode_o
);
  logic       cs_n_d_q;
  port_mode_e mode_q;
  logic       cs_fall;

  assign cs_fall = cs_n_d_q & ~cs_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_d_q <= 1'b1;
      mode_q   <= MODE_IDLE;
    end else begin
      cs_n_d_q <= cs_n_s_i;
      if (cs_n_s_i)     mode_q <= MODE_IDLE;
      else if (cs_fall) mode_q <= arm_i ? MODE_BURST : MODE_REG;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/bdl_shifter.sv
module bdl_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              vld_q;
  logic [WORD_W-1:0] sh_nxt;

  // LSB first: new bit enters at the top and drifts down to bit 0
  assign sh_nxt = {bit_i, sh_q[WORD_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      word_q <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (clr_i) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (bit_stb_i) begin
        sh_q <= sh_nxt;
        if (cnt_q == LAST_BIT) begin
          cnt_q  <= '0;
          word_q <= sh_nxt;
          vld_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;
endmodule

// File: rtl/bdl_addr_ctr.sv
module bdl_addr_ctr #(
  parameter int ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= start_i;
    else if (inc_i)  addr_q <= addr_q + 1'b1; // natural wrap at top
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/burst_dl_port.sv
module burst_dl_port
  import bdl_pkg::*;
#(
  parameter int P_ADDR_W = bdl_pkg::ADDR_W,
  parameter int P_WORD_W = bdl_pkg::WORD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_dl_i,
  input  logic [1:0]          prog_mode_i,
  input  logic                mem_en_i,
  input  logic                addr_load_i,
  input  logic [P_ADDR_W-1:0] start_addr_i,
  input  logic                cs_ni,
  input  logic                sclk_i,
  input  logic                sdi_i,
  output logic                sdo_o,
  output logic                sdo_oe_o,
  input  logic                reg_sdo_i,
  output logic                reg_sel_o,
  output logic                mem_we_o,
  output logic [P_ADDR_W-1:0] mem_addr_o,
  output logic [P_WORD_W-1:0] mem_wdata_o,
  output logic                mute_o,
  output logic                dec_abort_o
);
  logic [2:0] pins_s;
  logic       cs_n_s, sclk_s, sdi_s;
  logic       sclk_d_q;
  logic       sclk_rise;
  logic       arm;
  logic       in_burst;
  port_mode_e mode;

  bdl_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, sdi_i}),
    .q_o    (pins_s)
  );
  assign {cs_n_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s;
  end
  assign sclk_rise = sclk_s & ~sclk_d_q;

  assign arm = cfg_dl_i & (prog_mode_i == PMODE_BURST) & mem_en_i;

  bdl_mode_ctl u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_s_i (cs_n_s),
    .arm_i    (arm),
    .mode_o   (mode)
  );
  assign in_burst = (mode == MODE_BURST);

  bdl_shifter #(.WORD_W(P_WORD_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (~in_burst),
    .bit_stb_i  (sclk_rise),
    .bit_i      (sdi_s),
    .word_o     (mem_wdata_o),
    .word_vld_o (mem_we_o)
  );

  bdl_addr_ctr #(.ADDR_W(P_ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (addr_load_i & ~in_burst),
    .start_i (start_addr_i),
    .inc_i   (mem_we_o),
    .addr_o  (mem_addr_o)
  );

  assign reg_sel_o   = (mode == MODE_REG);
  assign sdo_oe_o    = reg_sel_o;
  assign sdo_o       = sdo_oe_o ? reg_sdo_i : 1'bz;
  assign mute_o      = in_burst;
  assign dec_abort_o = in_burst;
endmodule

// File: rtl/bdl_port_chk.sv
module bdl_port_chk #(
  parameter int P_ADDR_W = 21
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_dl_i,
  input logic [1:0]          prog_mode_i,
  input logic                mem_en_i,
  input logic                cs_ni,
  input logic                sdo_oe_o,
  input logic                mem_we_o,
  input logic [P_ADDR_W-1:0] mem_addr_o,
  input logic                mute_o
);
  p_we_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (mem_addr_o == P_ADDR_W'($past(mem_addr_o) + 1'b1)));

  p_entry_armed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mute_o) |-> $past(cfg_dl_i && (prog_mode_i == 2'b11) && mem_en_i));

  p_no_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |-> !sdo_oe_o);

  p_write_in_burst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mute_o);

  p_desel_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !sdo_oe_o);
endmodule

bind burst_dl_port bdl_port_chk #(.P_ADDR_W(P_ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_dl_i    (cfg_dl_i),
  .prog_mode_i (prog_mode_i),
  .mem_en_i    (mem_en_i),
  .cs_ni       (cs_ni),
  .sdo_oe_o    (sdo_oe_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mute_o      (mute_o)
);

// File: tb/burst_dl_port_tb_top.sv
module burst_dl_port_tb_top;
  localparam int AW = 21;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_dl_i = 1'b0;
  logic [1:0]    prog_mode_i = 2'b00;
  logic          mem_en_i = 1'b0;
  logic          addr_load_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic          cs_ni = 1'b1;
  logic          sclk_i = 1'b0;
  logic          sdi_i = 1'b0;
  wire           sdo_o;
  logic          sdo_oe_o;
  logic          reg_sdo_i = 1'b0;
  logic          reg_sel_o;
  logic          mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mute_o;
  logic          dec_abort_o;

  always #10 clk_i = ~clk_i; // 50 MHz

  burst_dl_port dut_i (
    .clk_i, .rst_ni, .cfg_dl_i, .prog_mode_i, .mem_en_i, .addr_load_i,
    .start_addr_i, .cs_ni, .sclk_i, .sdi_i, .sdo_o, .sdo_oe_o, .reg_sdo_i,
    .reg_sel_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mute_o, .dec_abort_o
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [AW+DW-1:0] exp_q [$];
  logic [AW-1:0]    exp_addr;
  logic             we_prev = 1'b0;
  bit               done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every write strobe
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (mem_we_o && we_prev)
        check(1'b0, "R3", "strobe longer than one clock", 64'd2, 64'd1);
      if (mem_we_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6/R8", "unexpected write addr", 64'(mem_addr_o), 64'd0);
        end else begin
          logic [AW+DW-1:0] e;
          e = exp_q.pop_front();
          check(mem_addr_o == e[AW+DW-1:DW], "R4", "write address",
                64'(mem_addr_o), 64'(e[AW+DW-1:DW]));
          check(mem_wdata_o == e[DW-1:0], "R2/R3", "write data",
                64'(mem_wdata_o), 64'(e[DW-1:0]));
        end
      end
      we_prev <= mem_we_o;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    @(negedge clk_i);
    start_addr_i = a; addr_load_i = 1'b1;
    @(negedge clk_i);
    addr_load_i = 1'b0;
    exp_addr = a;
  endtask

  task automatic set_arm(input bit on);
    cfg_dl_i = on; prog_mode_i = on ? 2'b11 : 2'b10; mem_en_i = on;
  endtask

  task automatic shift_bits(input int n, input logic [DW-1:0] d);
    for (int i = 0; i < n; i++) begin
      sdi_i = d[i];
      #80 sclk_i = 1'b1;
      #80 sclk_i = 1'b0;
    end
  endtask

  task automatic send_word(input logic [DW-1:0] d);
    exp_q.push_back({exp_addr, d});
    exp_addr = exp_addr + 1'b1;
    shift_bits(DW, d);
  endtask

  task automatic cs_low();  #3 cs_ni = 1'b0; wait_clk(6); endtask
  task automatic cs_high(); #40 cs_ni = 1'b1; wait_clk(6); endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin : stim
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);
    // R7 R8: reset state
    check(!mute_o && !dec_abort_o, "R7", "mute/abort after reset", 64'(mute_o), 0);
    check(!sdo_oe_o && !mem_we_o, "R8", "idle oe/we after reset", 64'(sdo_oe_o), 0);

    // R8: deselected activity
    shift_bits(40, 32'hDEAD_BEEF);
    wait_clk(6);
    check(exp_q.size() == 0 && !sdo_oe_o, "R8", "deselected oe", 64'(sdo_oe_o), 0);

    // R1: not fully armed -> register mode
    load_addr(21'h00100);
    cfg_dl_i = 1'b1; prog_mode_i = 2'b01; mem_en_i = 1'b1; reg_sdo_i = 1'b1;
    cs_low();
    check(reg_sel_o && sdo_oe_o && !mute_o, "R1", "register mode entry",
          64'({reg_sel_o, sdo_oe_o, mute_o}), 64'b110);
    check(sdo_o === 1'b1, "R1", "sdo follows reg data", 64'(sdo_o), 1);
    reg_sdo_i = 1'b0; wait_clk(4);
    check(sdo_o === 1'b0, "R1", "sdo follows reg data low", 64'(sdo_o), 0);
    shift_bits(DW, 32'h1234_5678); // must produce no write
    wait_clk(6);
    cs_high();
    check(!reg_sel_o && !sdo_oe_o, "R8", "deselect after reg mode", 64'(sdo_oe_o), 0);

    // R2 R4: armed burst, three words
    set_arm(1'b1);
    load_addr(21'h00100);
    cs_low();
    check(mute_o && dec_abort_o, "R7", "mute/abort in burst",
          64'({mute_o, dec_abort_o}), 64'b11);
    check(!sdo_oe_o && !reg_sel_o, "R10", "no drive in burst", 64'(sdo_oe_o), 0);
    send_word(32'h0000_0001);
    send_word(32'h8000_0000);
    // R9: reload attempt during burst is ignored
    @(negedge clk_i); start_addr_i = 21'h0ABCD; addr_load_i = 1'b1;
    @(negedge clk_i); addr_load_i = 1'b0;
    send_word(32'hA5C3_0F96);
    wait_clk(8);
    check(!sdo_oe_o, "R10", "no drive at burst end", 64'(sdo_oe_o), 0);
    // R6: partial word then deselect
    shift_bits(10, 32'h3FF);
    cs_high();
    check(!mute_o && !dec_abort_o, "R7", "mute released", 64'(mute_o), 0);

    // R6: next burst starts on word boundary
    load_addr(21'h00200);
    cs_low();
    send_word(32'hCAFE_F00D);
    wait_clk(8);
    cs_high();

    // R5: wrap at top of address space
    load_addr(21'h1FFFFF);
    cs_low();
    send_word(32'h1111_2222);
    send_word(32'h3333_4444);
    wait_clk(8);
    cs_high();

    // R1: arming dropped -> register mode, no write
    set_arm(1'b0);
    cs_low();
    check(reg_sel_o && !mute_o, "R1", "disarmed entry", 64'(reg_sel_o), 1);
    shift_bits(DW, 32'hFFFF_FFFF);
    wait_clk(8);
    cs_high();

    wait_clk(10);
    check(exp_q.size() == 0, "R4", "all expected writes seen", 64'(exp_q.size()), 0);
    finish_run();
  end
endmodule